// File: doc/BRIEF.md
# Bitwise-AND Register Slave

This block is a small slave on an AHB-Lite bus. It holds two 32-bit operand words that software writes, and it presents their bitwise AND as a read-only result word. The address decoder drives its select line. The slave captures the transfer address, direction and size during the address phase. On a write it commits the bus write data in the following cycle, which is the data phase.

It never inserts wait states and always answers OKAY. Only word-sized active transfers (non-sequential or sequential) reach the registers, so a burst is taken one beat at a time. The register map has the result word at offset 0x0, operand A at offset 0x4 and operand B at offset 0x8. The operands can also be read back. Any other offset inside the slave's window reads as zero and drops writes.

Top module: `and_reg_slave`

## Requirements
- R1: After reset both operands are zero, so reads of offsets 0x0, 0x4 and 0x8 all return zero.
- R2: A word write to offset 0x4 stores operand A, and a later read of 0x4 returns it.
- R3: A word write to offset 0x8 stores operand B, and a later read of 0x8 returns it.
- R4: A read of offset 0x0 returns operand A AND operand B, bit by bit.
- R5: The address, direction and offset are taken in the address phase, and the write data is taken from hwdata_i in the next cycle. A read of 0x0 issued in the cycle right after a write's address phase returns the AND value that includes that write.
- R6: Transfers with htrans_i equal to 0 (IDLE) or 1 (BUSY) change no register and produce no read data.
- R7: A transfer with hsel_i low changes no register and produces no read data.
- R8: Only hsize_i equal to 2 (32-bit word) is acted on. A transfer of any other size changes no register and reads as zero.
- R9: Writes to offset 0x0 or 0xC are discarded, and a read of 0xC returns zero. The word index is taken from haddr_i[3:2].
- R10: hready_o is always 1 and hresp_o is always 0 (OKAY), so there are no wait states.
- R11: hrdata_o is zero in every cycle that is not the data phase of an accepted read.
- R12: Sequential beats (htrans_i equal to 3) are accepted the same way as non-sequential ones.
- R13: An address phase presented while hready_i is low is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsel_i | input | 1 | Slave select from the address decoder |
| haddr_i | input | 32 | Transfer address |
| htrans_i | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite_i | input | 1 | 1 write, 0 read |
| hsize_i | input | 3 | Transfer size code, 2 means word |
| hwdata_i | input | 32 | Write data, valid in the data phase |
| hready_i | input | 1 | Bus-wide ready; the previous transfer has completed |
| hrdata_o | output | 32 | Read data |
| hready_o | output | 1 | Transfer done, always 1 |
| hresp_o | output | 1 | Response, always 0 (OKAY) |

## Verification
The hardest case is the overlap of two transfers. A write's data phase runs in the same cycle as the next transfer's address phase, and a result read placed right behind an operand write must see the new value. The stimulus covers this with back-to-back write-write-read sequences and with sequential burst beats, so the operand commit and the next address capture fall on the same clock edge. Ignored transfers (IDLE, BUSY, deselected, wrong size, stalled hready_i, unmapped offsets) are each followed at once by a read-back through the bus, so any register they wrongly change shows up at the output.

// File: rtl/and_slv_pkg.sv
package and_slv_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } htrans_e;

  localparam logic [2:0] SIZE_WORD = 3'd2;

  // active transfer = NONSEQ or SEQ
  function automatic logic is_active(input logic [1:0] tr);
    return tr == TR_NONSEQ || tr == TR_SEQ;
  endfunction
endpackage

// File: rtl/and_slv_addr_stage.sv
module and_slv_addr_stage
  import and_slv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  output logic              dp_valid_o,
  output logic              dp_write_o,
  output logic [IDX_W-1:0]  dp_idx_o
);
  logic accept;
  logic unused_addr;

  assign unused_addr = ^{haddr_i[ADDR_W-1:IDX_W+2], haddr_i[1:0]};
  assign accept = hsel_i && hready_i && is_active(htrans_i) && (hsize_i == SIZE_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_valid_o <= 1'b0;
      dp_write_o <= 1'b0;
      dp_idx_o   <= '0;
    end else if (hready_i) begin
      dp_valid_o <= accept;
      dp_write_o <= accept && hwrite_i;
      dp_idx_o   <= haddr_i[IDX_W+1:2];
    end
  end

  AST_IGNORE_IDLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && !htrans_i[1]) |=> !dp_valid_o); // R6
  AST_IGNORE_UNSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && !hsel_i) |=> !dp_valid_o); // R7
  AST_IGNORE_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hsize_i != SIZE_WORD) |=> !dp_valid_o); // R8
endmodule

// File: rtl/and_slv_regs.sv
module and_slv_regs #(
  parameter int DATA_W  = 32,
  parameter int NUM_OPS = 2,
  parameter int IDX_W   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_OPS-1:0][DATA_W-1:0] ops_o,
  output logic [DATA_W-1:0]              res_o
);
  // word index 0 is the result; operand k sits at index k+1
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ops_o[k] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(k + 1))
        ops_o[k] <= wdata_i;
    end

    AST_OP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(k + 1)) |=> ops_o[k] == $past(wdata_i)); // R2
  end

  always_comb begin
    res_o = '1;
    for (int k = 0; k < NUM_OPS; k++) res_o &= ops_o[k];
  end

  AST_OPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ops_o)); // R6
endmodule

// File: rtl/and_reg_slave.sv
module and_reg_slave #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_OPS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic [DATA_W-1:0] hwdata_i,
  input  logic              hready_i,
  output logic [DATA_W-1:0] hrdata_o,
  output logic              hready_o,
  output logic              hresp_o
);
  localparam int IDX_W = $clog2(NUM_OPS + 1);

  logic                           dp_valid, dp_write;
  logic [IDX_W-1:0]               dp_idx;
  logic [NUM_OPS-1:0][DATA_W-1:0] ops;
  logic [DATA_W-1:0]              res;

  and_slv_addr_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsel_i(hsel_i), .haddr_i(haddr_i),
    .htrans_i(htrans_i), .hwrite_i(hwrite_i), .hsize_i(hsize_i), .hready_i(hready_i),
    .dp_valid_o(dp_valid), .dp_write_o(dp_write), .dp_idx_o(dp_idx)
  );

  and_slv_regs #(.DATA_W(DATA_W), .NUM_OPS(NUM_OPS), .IDX_W(IDX_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(dp_write), .wr_idx_i(dp_idx),
    .wdata_i(hwdata_i), .ops_o(ops), .res_o(res)
  );

  always_comb begin
    hrdata_o = '0;
    if (dp_valid && !dp_write) begin
      if (dp_idx == '0) hrdata_o = res;
      for (int k = 0; k < NUM_OPS; k++)
        if (dp_idx == IDX_W'(k + 1)) hrdata_o = ops[k];
    end
  end

  assign hready_o = 1'b1;
  assign hresp_o  = 1'b0;

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_valid && !dp_write) |-> hrdata_o == '0); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_valid && !dp_write && dp_idx > IDX_W'(NUM_OPS)) |-> hrdata_o == '0); // R9
  AST_READ_OP0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_valid && !dp_write && dp_idx == IDX_W'(1)) |-> hrdata_o == ops[0]); // R2
endmodule

// File: tb/tb_and_reg_slave.sv
module tb_and_reg_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        hsel_i = 1'b0, hwrite_i = 1'b0, hready_i = 1'b1;
  logic [31:0] haddr_i = '0, hwdata_i = '0;
  logic [1:0]  htrans_i = '0;
  logic [2:0]  hsize_i = 3'd2;
  logic [31:0] hrdata_o;
  logic        hready_o, hresp_o;

  and_reg_slave dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_a = '0, m_b = '0;
  bit          p_valid = 0, p_write = 0;
  logic [1:0]  p_idx = '0;
  logic [31:0] p_wdata = '0;
  string       p_tag = "R11";

  function automatic logic [31:0] model_read(input logic [1:0] idx);
    case (idx)
      2'd0: return m_a & m_b;
      2'd1: return m_a;
      2'd2: return m_b;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic sel, input logic [1:0] tr, input logic wr,
                      input logic [2:0] sz, input logic [31:0] ad,
                      input logic [31:0] wd, input logic rdy, input string tag);
    hwdata_i = p_wdata;
    hsel_i = sel; htrans_i = tr; hwrite_i = wr; hsize_i = sz; haddr_i = ad; hready_i = rdy;
    #1;
    if (p_valid && !p_write) check(p_tag, hrdata_o, model_read(p_idx));
    else                     check("R11", hrdata_o, 32'h0);
    check("R10", {31'h0, hready_o}, 32'h1);
    check("R10", {31'h0, hresp_o}, 32'h0);
    @(posedge clk_i);
    if (p_valid && p_write) begin
      if (p_idx == 2'd1) m_a = p_wdata;
      if (p_idx == 2'd2) m_b = p_wdata;
    end
    p_valid = sel && rdy && tr[1] && sz == 3'd2;
    p_write = wr;
    p_idx   = ad[3:2];
    p_wdata = wd;
    p_tag   = tag;
    @(negedge clk_i);
  endtask

  task automatic wr_w(input logic [31:0] ad, input logic [31:0] wd, input string tag);
    step(1, 2'd2, 1, 3'd2, ad, wd, 1, tag);
  endtask
  task automatic rd_w(input logic [31:0] ad, input string tag);
    step(1, 2'd2, 0, 3'd2, ad, 32'h0, 1, tag);
  endtask
  task automatic idle();
    step(0, 2'd0, 0, 3'd2, 32'h0, 32'h0, 1, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1; check("R1", hrdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset values
    rd_w(32'h0, "R1"); rd_w(32'h4, "R1"); rd_w(32'h8, "R1"); idle();
    // R2 R3 R4 R5 back-to-back write, write, result read
    wr_w(32'h4, 32'h1111_1000, "R2");
    wr_w(32'h8, 32'h0000_1111, "R3");
    rd_w(32'h0, "R5");
    rd_w(32'h4, "R2"); rd_w(32'h8, "R3"); rd_w(32'h0, "R4"); idle();
    // R6 IDLE and BUSY writes ignored
    step(1, 2'd0, 1, 3'd2, 32'h4, 32'hDEAD_BEEF, 1, "R6");
    step(1, 2'd1, 1, 3'd2, 32'h8, 32'hCAFE_F00D, 1, "R6");
    rd_w(32'h4, "R6"); rd_w(32'h8, "R6");
    step(1, 2'd0, 0, 3'd2, 32'h0, 32'h0, 1, "R6"); idle();
    // R7 deselected
    step(0, 2'd2, 1, 3'd2, 32'h4, 32'h1234_5678, 1, "R7");
    step(0, 2'd2, 0, 3'd2, 32'h4, 32'h0, 1, "R7");
    rd_w(32'h4, "R7");
    // R8 non-word sizes
    step(1, 2'd2, 1, 3'd0, 32'h4, 32'hFFFF_FFFF, 1, "R8");
    step(1, 2'd2, 1, 3'd1, 32'h8, 32'hFFFF_FFFF, 1, "R8");
    step(1, 2'd2, 0, 3'd0, 32'h4, 32'h0, 1, "R8");
    rd_w(32'h4, "R8"); rd_w(32'h8, "R8");
    // R9 unmapped and result-location writes dropped
    wr_w(32'hC, 32'hA5A5_A5A5, "R9");
    rd_w(32'hC, "R9");
    wr_w(32'h0, 32'h5A5A_5A5A, "R9");
    rd_w(32'h0, "R9"); rd_w(32'h4, "R9"); rd_w(32'h8, "R9");
    rd_w(32'h1000_000C, "R9"); idle();
    // R12 burst: NONSEQ then SEQ beats
    step(1, 2'd2, 1, 3'd2, 32'h4, 32'hF0F0_FF00, 1, "R12");
    step(1, 2'd3, 1, 3'd2, 32'h8, 32'h3C3C_0FF0, 1, "R12");
    step(1, 2'd3, 0, 3'd2, 32'hC, 32'h0, 1, "R12");
    step(1, 2'd2, 0, 3'd2, 32'h0, 32'h0, 1, "R12");
    step(1, 2'd3, 0, 3'd2, 32'h4, 32'h0, 1, "R12");
    step(1, 2'd3, 0, 3'd2, 32'h8, 32'h0, 1, "R12"); idle();
    // R13 stalled address phase
    step(1, 2'd2, 1, 3'd2, 32'h4, 32'h0BAD_0BAD, 0, "R13");
    idle();
    rd_w(32'h4, "R13"); idle();
    // R4 R5 several patterns, write immediately followed by result read
    for (int i = 0; i < 24; i++) begin
      logic [31:0] va, vb;
      va = 32'h9E37_79B9 * (i + 1);
      vb = {va[15:0], va[31:16]} ^ (32'h0101_0101 << (i % 8));
      wr_w(32'h4, va, "R2");
      rd_w(32'h0, "R5");
      wr_w(32'h8, vb, "R3");
      rd_w(32'h0, "R4");
    end
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule